// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block decides when a UART may send and when its peer may send. It watches the fill level of the receive FIFO and drives the ready-to-send line (`rts`) with hysteresis. The line drops when the fill climbs to a programmable halt level. It returns only once the fill has drained to a separate, lower resume level. Both levels are 4-bit fields counted in units of eight words of a 128-word FIFO. When automatic control is off, `rts` simply follows a configuration bit.

On the transmit side the block produces `txAllow`, the permission for the serializer to start a new character. Three things can withdraw it: the peer's clear-to-send input (when automatic clear-to-send is on), a received stop character (when automatic software flow control is on), and a plain transmit-disable bit. A character already on the wire is always finished before the permission changes. Received characters are compared against two programmable start/stop character pairs. A 2-bit pair selector chooses which pair is active, or requires the two-character sequence made of both pairs. Each match yields a one-cycle event pulse.

With echo suppression enabled, characters that arrive while the local transmitter is busy are neither written to the receive FIFO nor examined for flow characters.

Top module: `uart_flow_ctl`

## Requirements
- R1: While reset is asserted, `txAllow`, `evtXon` and `evtXoff` are 0 and `rts` is 1 with automatic RTS selected; `txAllow` becomes 1 on the first clock edge after reset is released if nothing stops transmission.
- R2: With `cfgAutoRts`=1, when `rxFill` >= 8*`cfgHaltLvl` at a clock edge, `rts` is 0 after that edge.
- R3: With `cfgAutoRts`=1, once `rts` is 0 it stays 0 until an edge at which `rxFill` <= 8*`cfgResumeLvl` (and below the halt level); `rts` is 1 after that edge.
- R4: With `cfgAutoRts`=0, `rts` equals `cfgRtsLevel` combinationally, whatever the fill level.
- R5: `cfgPairSel` encoding: 2'b10 uses pair 1 (`cfgXon1`/`cfgXoff1`), 2'b01 uses pair 2 (`cfgXon2`/`cfgXoff2`); an accepted character equal to the active stop (start) character gives a one-cycle pulse on `evtXoff` (`evtXon`) in the cycle after the strobe; a character matching both gives only `evtXoff`.
- R6: With `cfgPairSel`=2'b11, `evtXoff` pulses only when an accepted `cfgXoff2` directly follows an accepted `cfgXoff1`, and `evtXon` only when `cfgXon2` directly follows `cfgXon1`.
- R7: With `cfgPairSel`=2'b00, no character produces an event.
- R8: With `cfgAutoXon`=1, a stop event withdraws `txAllow` two cycles after the strobe, and a start event restores it two cycles after its strobe; reception (`rxWrEn`) is unaffected. Clearing `cfgAutoXon` releases a held stop.
- R9: With `cfgAutoCts`=1, `ctsIn`=0 makes `txAllow` 0 one cycle later, and `ctsIn`=1 restores it; with `cfgAutoCts`=0, `ctsIn` has no effect.
- R10: While `txBusy`=1 and `txCharEnd`=0, `txAllow` does not change; a pending stop takes effect at the edge where `txCharEnd`=1 or `txBusy`=0.
- R11: With `cfgEchoSupp`=1 and `txBusy`=1, a strobe gives `rxWrEn`=0 and no event; otherwise `rxWrEn` follows `rxStrobe`.
- R12: `cfgTxDisable`=1 makes `txAllow` 0 one cycle later while the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgAutoRts | input | 1 | Drive `rts` from fill level |
| cfgRtsLevel | input | 1 | Direct `rts` value when automatic RTS is off |
| cfgHaltLvl | input | 4 | Halt threshold, units of 8 words |
| cfgResumeLvl | input | 4 | Resume threshold, units of 8 words |
| cfgAutoCts | input | 1 | Gate transmit on `ctsIn` |
| cfgAutoXon | input | 1 | Gate transmit on received start/stop characters |
| cfgPairSel | input | 2 | Active character pair selection |
| cfgXon1 | input | 8 | Start character, pair 1 |
| cfgXoff1 | input | 8 | Stop character, pair 1 |
| cfgXon2 | input | 8 | Start character, pair 2 |
| cfgXoff2 | input | 8 | Stop character, pair 2 |
| cfgEchoSupp | input | 1 | Drop received data while transmitting |
| cfgTxDisable | input | 1 | Halt transmission after the current character |
| rxFill | input | 8 | Receive FIFO fill level, 0..128 |
| rxStrobe | input | 1 | Received character valid |
| rxData | input | 8 | Received character |
| txBusy | input | 1 | Transmitter is sending a character |
| txCharEnd | input | 1 | Transmitter is at a character boundary |
| ctsIn | input | 1 | Peer clear-to-send, 1 = may send |
| rts | output | 1 | Ready-to-send to peer, 1 = may send to us |
| txAllow | output | 1 | Transmitter may start a new character |
| rxWrEn | output | 1 | Write enable into the receive FIFO |
| evtXon | output | 1 | Start-character event pulse |
| evtXoff | output | 1 | Stop-character event pulse |

## Verification
The bench walks the fill level through the band between resume and halt. A design without hysteresis would reassert `rts` there, and one with an off-by-one comparison would move it a word early or late. In the two-character mode it sends the second character alone and after an unrelated character. A design that matched single characters would fire an event where none is due. It raises a stop request in the middle of a character and checks that permission holds until the boundary. It also sends a stop character as an echo while transmitting, which a design that still examined suppressed data would act on.

// File: rtl/flow_ctl_pkg.sv
`timescale 1ns/1ps
package flow_ctl_pkg;

  // Encoding of the character pair selector
  typedef enum logic [1:0] {
    PAIR_NONE = 2'b00,
    PAIR_TWO  = 2'b01,
    PAIR_ONE  = 2'b10,
    PAIR_BOTH = 2'b11
  } pairMode_e;

  // Strobes from the datapath to the control
  typedef struct packed {
    logic xonHit;
    logic xoffHit;
    logic fillAtHalt;
    logic fillAtResume;
  } fcStrobes_t;

endpackage

// File: rtl/flow_ctl_dp.sv
`timescale 1ns/1ps
module flow_ctl_dp
  import flow_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int THR_W      = 4,
  parameter int THR_UNIT   = 8,
  parameter int CHAR_W     = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int NUM_PAIRS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  cfgHaltLvl,
  input  logic [THR_W-1:0]  cfgResumeLvl,
  input  logic [1:0]        cfgPairSel,
  input  logic [CHAR_W-1:0] cfgXon1,
  input  logic [CHAR_W-1:0] cfgXoff1,
  input  logic [CHAR_W-1:0] cfgXon2,
  input  logic [CHAR_W-1:0] cfgXoff2,
  input  logic              cfgEchoSupp,
  input  logic [LVL_W-1:0]  rxFill,
  input  logic              rxStrobe,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              txBusy,
  output logic              rxWrEn,
  output fcStrobes_t        strb
);

  localparam int CMP_W = LVL_W + THR_W;

  // Threshold scaling into words
  logic [CMP_W-1:0] haltWords;
  logic [CMP_W-1:0] resumeWords;
  logic [CMP_W-1:0] fillWide;

  assign haltWords   = CMP_W'(cfgHaltLvl) * CMP_W'(THR_UNIT);
  assign resumeWords = CMP_W'(cfgResumeLvl) * CMP_W'(THR_UNIT);
  assign fillWide    = CMP_W'(rxFill);

  // Echo gate: a character is accepted unless it arrives while sending
  logic chrAccept;
  assign chrAccept = rxStrobe && !(cfgEchoSupp && txBusy);
  assign rxWrEn    = chrAccept;

  // Character pair comparison
  logic [CHAR_W-1:0] xonChr  [NUM_PAIRS];
  logic [CHAR_W-1:0] xoffChr [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] curXonEq;
  logic [NUM_PAIRS-1:0] curXoffEq;

  assign xonChr[0]  = cfgXon1;
  assign xonChr[1]  = cfgXon2;
  assign xoffChr[0] = cfgXoff1;
  assign xoffChr[1] = cfgXoff2;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign curXonEq[p]  = (rxData == xonChr[p]);
    assign curXoffEq[p] = (rxData == xoffChr[p]);
  end

  // Previous accepted character for the two-character sequence mode
  logic [CHAR_W-1:0] prevChar;
  logic              prevValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevChar  <= '0;
      prevValid <= 1'b0;
    end else if (chrAccept) begin
      prevChar  <= rxData;
      prevValid <= 1'b1;
    end
  end

  logic prevXon1Eq;
  logic prevXoff1Eq;
  assign prevXon1Eq  = prevValid && (prevChar == cfgXon1);
  assign prevXoff1Eq = prevValid && (prevChar == cfgXoff1);

  logic xonRaw;
  logic xoffRaw;

  always_comb begin
    xonRaw  = 1'b0;
    xoffRaw = 1'b0;
    case (pairMode_e'(cfgPairSel))
      PAIR_ONE: begin
        xonRaw  = curXonEq[0];
        xoffRaw = curXoffEq[0];
      end
      PAIR_TWO: begin
        xonRaw  = curXonEq[1];
        xoffRaw = curXoffEq[1];
      end
      PAIR_BOTH: begin
        xonRaw  = curXonEq[1] && prevXon1Eq;
        xoffRaw = curXoffEq[1] && prevXoff1Eq;
      end
      default: begin
        xonRaw  = 1'b0;
        xoffRaw = 1'b0;
      end
    endcase
  end

  always_comb begin
    strb.xoffHit      = chrAccept && xoffRaw;
    strb.xonHit       = chrAccept && xonRaw && !xoffRaw;
    strb.fillAtHalt   = (fillWide >= haltWords);
    strb.fillAtResume = (fillWide <= resumeWords);
  end

endmodule

// File: rtl/flow_ctl_ctrl.sv
`timescale 1ns/1ps
module flow_ctl_ctrl
  import flow_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgAutoRts,
  input  logic       cfgRtsLevel,
  input  logic       cfgAutoCts,
  input  logic       cfgAutoXon,
  input  logic       cfgTxDisable,
  input  logic       ctsIn,
  input  logic       txBusy,
  input  logic       txCharEnd,
  input  fcStrobes_t strb,
  output logic       rts,
  output logic       txAllow,
  output logic       evtXon,
  output logic       evtXoff
);

  // RTS hysteresis: halt has priority over resume
  logic rtsHalted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rtsHalted <= 1'b0;
    else if (strb.fillAtHalt)   rtsHalted <= 1'b1;
    else if (strb.fillAtResume) rtsHalted <= 1'b0;
  end

  assign rts = cfgAutoRts ? !rtsHalted : cfgRtsLevel;

  // Software flow state
  logic xoffHeld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            xoffHeld <= 1'b0;
    else if (!cfgAutoXon)  xoffHeld <= 1'b0;
    else if (strb.xoffHit) xoffHeld <= 1'b1;
    else if (strb.xonHit)  xoffHeld <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtXon  <= 1'b0;
      evtXoff <= 1'b0;
    end else begin
      evtXon  <= strb.xonHit;
      evtXoff <= strb.xoffHit;
    end
  end

  // Transmit permission, changed only between characters
  logic stopCond;
  logic atBoundary;
  logic txAllowQ;

  assign stopCond   = cfgTxDisable || (cfgAutoCts && !ctsIn) || xoffHeld;
  assign atBoundary = !txBusy || txCharEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          txAllowQ <= 1'b0;
    else if (atBoundary) txAllowQ <= !stopCond;
  end

  assign txAllow = txAllowQ;

  // R2: reaching the halt level deasserts automatic RTS
  a_r2_halt_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoRts && strb.fillAtHalt) |=> (!rts || !cfgAutoRts));

  // R3: a halted RTS stays low until the resume level is reached
  a_r3_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAutoRts && !rts && !strb.fillAtResume) |=> (!rts || !cfgAutoRts));

  // R8: a held stop keeps an idle transmitter blocked
  a_r8_xoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (xoffHeld && !txBusy) |=> !txAllow);

  // R10: no change of permission in the middle of a character
  a_r10_mid_char_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txBusy && !txCharEnd) |=> $stable(txAllow));

  // R12: disable stops an idle transmitter
  a_r12_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgTxDisable && !txBusy) |=> !txAllow);

endmodule

// File: rtl/uart_flow_ctl.sv
`timescale 1ns/1ps
module uart_flow_ctl
  import flow_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int THR_W      = 4,
  parameter int THR_UNIT   = 8,
  parameter int CHAR_W     = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfgAutoRts,
  input  logic                               cfgRtsLevel,
  input  logic [THR_W-1:0]                   cfgHaltLvl,
  input  logic [THR_W-1:0]                   cfgResumeLvl,
  input  logic                               cfgAutoCts,
  input  logic                               cfgAutoXon,
  input  logic [1:0]                         cfgPairSel,
  input  logic [CHAR_W-1:0]                  cfgXon1,
  input  logic [CHAR_W-1:0]                  cfgXoff1,
  input  logic [CHAR_W-1:0]                  cfgXon2,
  input  logic [CHAR_W-1:0]                  cfgXoff2,
  input  logic                               cfgEchoSupp,
  input  logic                               cfgTxDisable,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]    rxFill,
  input  logic                               rxStrobe,
  input  logic [CHAR_W-1:0]                  rxData,
  input  logic                               txBusy,
  input  logic                               txCharEnd,
  input  logic                               ctsIn,
  output logic                               rts,
  output logic                               txAllow,
  output logic                               rxWrEn,
  output logic                               evtXon,
  output logic                               evtXoff
);

  fcStrobes_t strb;

  flow_ctl_dp #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .THR_W      (THR_W),
    .THR_UNIT   (THR_UNIT),
    .CHAR_W     (CHAR_W)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgHaltLvl   (cfgHaltLvl),
    .cfgResumeLvl (cfgResumeLvl),
    .cfgPairSel   (cfgPairSel),
    .cfgXon1      (cfgXon1),
    .cfgXoff1     (cfgXoff1),
    .cfgXon2      (cfgXon2),
    .cfgXoff2     (cfgXoff2),
    .cfgEchoSupp  (cfgEchoSupp),
    .rxFill       (rxFill),
    .rxStrobe     (rxStrobe),
    .rxData       (rxData),
    .txBusy       (txBusy),
    .rxWrEn       (rxWrEn),
    .strb         (strb)
  );

  flow_ctl_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgAutoRts   (cfgAutoRts),
    .cfgRtsLevel  (cfgRtsLevel),
    .cfgAutoCts   (cfgAutoCts),
    .cfgAutoXon   (cfgAutoXon),
    .cfgTxDisable (cfgTxDisable),
    .ctsIn        (ctsIn),
    .txBusy       (txBusy),
    .txCharEnd    (txCharEnd),
    .strb         (strb),
    .rts          (rts),
    .txAllow      (txAllow),
    .evtXon       (evtXon),
    .evtXoff      (evtXoff)
  );

  // R5: start and stop events never coincide
  a_r5_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(evtXon && evtXoff));

  // R7: no detection with the selector at zero
  a_r7_no_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgPairSel == 2'b00) |=> (!evtXon && !evtXoff));

  // R11: suppressed echoes never produce an event
  a_r11_echo_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && cfgEchoSupp && txBusy) |=> (!evtXon && !evtXoff));

endmodule

// File: tb/uart_flow_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_flow_ctl_tb_top;

  localparam int SIG_RTS  = 0;
  localparam int SIG_TXA  = 1;
  localparam int SIG_WR   = 2;
  localparam int SIG_XON  = 3;
  localparam int SIG_XOFF = 4;

  localparam logic [7:0] XON1  = 8'h11;
  localparam logic [7:0] XOFF1 = 8'h13;
  localparam logic [7:0] XON2  = 8'h21;
  localparam logic [7:0] XOFF2 = 8'h23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgAutoRts = 1'b1;
  logic cfgRtsLevel = 1'b1;
  logic [3:0] cfgHaltLvl = 4'd4;
  logic [3:0] cfgResumeLvl = 4'd2;
  logic cfgAutoCts = 1'b0;
  logic cfgAutoXon = 1'b0;
  logic [1:0] cfgPairSel = 2'b00;
  logic cfgEchoSupp = 1'b0;
  logic cfgTxDisable = 1'b0;
  logic [7:0] rxFill = 8'd0;
  logic rxStrobe = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic txBusy = 1'b0;
  logic txCharEnd = 1'b0;
  logic ctsIn = 1'b1;
  logic rts, txAllow, rxWrEn, evtXon, evtXoff;

  uart_flow_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfgAutoRts(cfgAutoRts), .cfgRtsLevel(cfgRtsLevel),
    .cfgHaltLvl(cfgHaltLvl), .cfgResumeLvl(cfgResumeLvl),
    .cfgAutoCts(cfgAutoCts), .cfgAutoXon(cfgAutoXon),
    .cfgPairSel(cfgPairSel),
    .cfgXon1(XON1), .cfgXoff1(XOFF1), .cfgXon2(XON2), .cfgXoff2(XOFF2),
    .cfgEchoSupp(cfgEchoSupp), .cfgTxDisable(cfgTxDisable),
    .rxFill(rxFill), .rxStrobe(rxStrobe), .rxData(rxData),
    .txBusy(txBusy), .txCharEnd(txCharEnd), .ctsIn(ctsIn),
    .rts(rts), .txAllow(txAllow), .rxWrEn(rxWrEn),
    .evtXon(evtXon), .evtXoff(evtXoff)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    int    sig;
    bit    exp;
    string tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  function automatic bit sigVal(int s);
    case (s)
      SIG_RTS:  return rts;
      SIG_TXA:  return txAllow;
      SIG_WR:   return rxWrEn;
      SIG_XON:  return evtXon;
      default:  return evtXoff;
    endcase
  endfunction

  function automatic string sigName(int s);
    case (s)
      SIG_RTS:  return "rts";
      SIG_TXA:  return "txAllow";
      SIG_WR:   return "rxWrEn";
      SIG_XON:  return "evtXon";
      default:  return "evtXoff";
    endcase
  endfunction

  // Monitor: compares due items away from the clock edge
  initial forever begin
    item_t keep[$];
    @(negedge clk);
    #1;
    keep = {};
    foreach (sb[i]) begin
      if (sb[i].due <= cyc) begin
        bit act;
        act = sigVal(sb[i].sig);
        nVec++;
        if (act !== sb[i].exp) begin
          nBad++;
          $display("FAIL %s %s cycle %0d: actual %0b expected %0b",
                   sb[i].tag, sigName(sb[i].sig), cyc, act, sb[i].exp);
        end
      end else begin
        keep.push_back(sb[i]);
      end
    end
    sb = keep;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expectAt(int sig, int dly, bit exp, string tag);
    item_t it;
    it.due = cyc + dly;
    it.sig = sig;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // One received character; events are expected one cycle later
  task automatic sendChar(logic [7:0] d, bit expWr, bit expOn, bit expOff, string tag);
    step();
    rxStrobe = 1'b1;
    rxData   = d;
    expectAt(SIG_WR, 0, expWr, tag);
    expectAt(SIG_XON, 1, expOn, tag);
    expectAt(SIG_XOFF, 1, expOff, tag);
    step();
    rxStrobe = 1'b0;
    expectAt(SIG_XON, 1, 1'b0, tag);
    expectAt(SIG_XOFF, 1, 1'b0, tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  // Driver
  initial begin
    // R1: state during reset
    step();
    expectAt(SIG_RTS, 0, 1'b1, "R1");
    expectAt(SIG_TXA, 0, 1'b0, "R1");
    expectAt(SIG_XON, 0, 1'b0, "R1");
    expectAt(SIG_XOFF, 0, 1'b0, "R1");
    step();
    rst_n = 1'b1;
    expectAt(SIG_TXA, 1, 1'b1, "R1");
    idle(2);

    // R2: halt at 8*4 = 32 words
    rxFill = 8'd31;
    expectAt(SIG_RTS, 1, 1'b1, "R2");
    step();
    rxFill = 8'd32;
    expectAt(SIG_RTS, 1, 1'b0, "R2");
    idle(2);

    // R3: hysteresis down to 8*2 = 16 words
    rxFill = 8'd20;
    expectAt(SIG_RTS, 1, 1'b0, "R3");
    step();
    rxFill = 8'd17;
    expectAt(SIG_RTS, 1, 1'b0, "R3");
    step();
    rxFill = 8'd16;
    expectAt(SIG_RTS, 1, 1'b1, "R3");
    step();
    rxFill = 8'd31;
    expectAt(SIG_RTS, 1, 1'b1, "R3");
    step();
    rxFill = 8'd128;
    expectAt(SIG_RTS, 1, 1'b0, "R2");
    step();
    rxFill = 8'd0;
    expectAt(SIG_RTS, 1, 1'b1, "R3");
    idle(2);

    // R4: direct control
    cfgAutoRts = 1'b0;
    cfgRtsLevel = 1'b0;
    expectAt(SIG_RTS, 0, 1'b0, "R4");
    step();
    rxFill = 8'd128;
    cfgRtsLevel = 1'b1;
    expectAt(SIG_RTS, 0, 1'b1, "R4");
    expectAt(SIG_RTS, 2, 1'b1, "R4");
    idle(3);
    rxFill = 8'd0;
    step();
    cfgAutoRts = 1'b1;
    idle(2);

    // R5: single pair matching
    cfgPairSel = 2'b10;
    sendChar(XOFF1, 1'b1, 1'b0, 1'b1, "R5");
    sendChar(XON1,  1'b1, 1'b1, 1'b0, "R5");
    sendChar(XOFF2, 1'b1, 1'b0, 1'b0, "R5");
    cfgPairSel = 2'b01;
    sendChar(XOFF2, 1'b1, 1'b0, 1'b1, "R5");
    sendChar(XON2,  1'b1, 1'b1, 1'b0, "R5");
    sendChar(XON1,  1'b1, 1'b0, 1'b0, "R5");

    // R6: two-character sequences
    cfgPairSel = 2'b11;
    sendChar(8'h55, 1'b1, 1'b0, 1'b0, "R6");
    sendChar(XOFF2, 1'b1, 1'b0, 1'b0, "R6");
    sendChar(XOFF1, 1'b1, 1'b0, 1'b0, "R6");
    sendChar(XOFF2, 1'b1, 1'b0, 1'b1, "R6");
    sendChar(XON1,  1'b1, 1'b0, 1'b0, "R6");
    sendChar(XON2,  1'b1, 1'b1, 1'b0, "R6");

    // R7: no detection
    cfgPairSel = 2'b00;
    sendChar(XOFF1, 1'b1, 1'b0, 1'b0, "R7");
    sendChar(XON2,  1'b1, 1'b0, 1'b0, "R7");
    idle(2);

    // R8: software flow gating
    cfgPairSel = 2'b10;
    cfgAutoXon = 1'b1;
    step();
    rxStrobe = 1'b1;
    rxData = XOFF1;
    expectAt(SIG_WR, 0, 1'b1, "R8");
    expectAt(SIG_TXA, 1, 1'b1, "R8");
    expectAt(SIG_TXA, 2, 1'b0, "R8");
    step();
    rxStrobe = 1'b0;
    idle(3);
    expectAt(SIG_TXA, 0, 1'b0, "R8");
    step();
    rxStrobe = 1'b1;
    rxData = XON1;
    expectAt(SIG_TXA, 1, 1'b0, "R8");
    expectAt(SIG_TXA, 2, 1'b1, "R8");
    step();
    rxStrobe = 1'b0;
    idle(2);
    sendChar(XOFF1, 1'b1, 1'b0, 1'b1, "R8");
    idle(2);
    expectAt(SIG_TXA, 0, 1'b0, "R8");
    step();
    cfgAutoXon = 1'b0;
    expectAt(SIG_TXA, 2, 1'b1, "R8");
    idle(3);

    // R9: CTS gating
    cfgAutoCts = 1'b1;
    ctsIn = 1'b0;
    expectAt(SIG_TXA, 1, 1'b0, "R9");
    step();
    ctsIn = 1'b1;
    expectAt(SIG_TXA, 1, 1'b1, "R9");
    step();
    cfgAutoCts = 1'b0;
    ctsIn = 1'b0;
    expectAt(SIG_TXA, 1, 1'b1, "R9");
    expectAt(SIG_TXA, 2, 1'b1, "R9");
    idle(3);
    ctsIn = 1'b1;
    step();

    // R10 and R12: stop requested mid-character
    txBusy = 1'b1;
    cfgTxDisable = 1'b1;
    expectAt(SIG_TXA, 1, 1'b1, "R10");
    expectAt(SIG_TXA, 2, 1'b1, "R10");
    expectAt(SIG_TXA, 3, 1'b1, "R10");
    idle(3);
    txCharEnd = 1'b1;
    expectAt(SIG_TXA, 1, 1'b0, "R10");
    step();
    txCharEnd = 1'b0;
    step();
    txBusy = 1'b0;
    cfgTxDisable = 1'b0;
    expectAt(SIG_TXA, 1, 1'b1, "R12");
    step();
    cfgTxDisable = 1'b1;
    expectAt(SIG_TXA, 1, 1'b0, "R12");
    step();
    cfgTxDisable = 1'b0;
    expectAt(SIG_TXA, 1, 1'b1, "R12");
    idle(2);

    // R11: echo suppression
    cfgPairSel = 2'b10;
    cfgEchoSupp = 1'b1;
    txBusy = 1'b1;
    txCharEnd = 1'b1;
    sendChar(XOFF1, 1'b0, 1'b0, 1'b0, "R11");
    txBusy = 1'b0;
    txCharEnd = 1'b0;
    sendChar(XOFF1, 1'b1, 1'b0, 1'b1, "R11");
    cfgEchoSupp = 1'b0;
    txBusy = 1'b1;
    txCharEnd = 1'b1;
    sendChar(XON1, 1'b1, 1'b1, 1'b0, "R11");
    txBusy = 1'b0;
    txCharEnd = 1'b0;

    idle(5);
    done = 1'b1;
    finishRun();
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule